// File: doc/BRIEF.md
# PHY Interrupt Cause Aggregator

This block collects single-cycle event pulses from an Ethernet PHY core into a sticky 16-bit pending register. A 16-bit mask register decides which pending events may drive one level-sensitive, active-high interrupt line. Bit 15 of the mask is a master switch. When it is clear, the line stays low whatever is pending.

Software reaches both registers through a small register port. A write with the mask selected loads the mask. A read of the mask returns it. A read of the pending register returns the pending bits and clears them. The response comes back one cycle after the read strobe.

Besides the interrupt line, two class outputs summarise the enabled pending causes:

- a link/configuration-change class, covering link change, autonegotiation error and autonegotiation done;
- a FIFO-error class, covering receive and transmit FIFO over/underflow.

The event bits are, by position: 0 receive error, 1 master/slave resolution error, 2 cable impairment, 3 false carrier, 4 media change, 5 Rx FIFO over/underflow, 6 Tx FIFO over/underflow, 7 descrambler lock lost, 8 symbol error, 10 autonegotiation done, 11 autonegotiation error, 13 link change. Bits 9, 12, 14 and 15 carry no event.

The read port is a three-state machine:

| State | Meaning |
|---|---|
| `PORT_IDLE` | No response is presented. |
| `PORT_RESP_EN` | The mask-read response is presented. |
| `PORT_RESP_STAT` | The pending-read response is presented. |

Its transitions are evaluated from every state, each for one cycle:

| Transition | Condition | Next state |
|---|---|---|
| `go_resp_en` | read strobe with `reg_sel`=0 | `PORT_RESP_EN` |
| `go_resp_stat` | read strobe with `reg_sel`=1 | `PORT_RESP_STAT` |
| `go_idle` | no read strobe | `PORT_IDLE` |

Top module: `phy_irq_aggregator`

## Requirements
- R1: After reset, the mask register and the pending register are zero, and `irq`, `cls_link`, `cls_fifo` and `rd_valid` are low.
- R2: An event pulse on `evt_pulse[i]` (i in 0-8, 10, 11, 13) sets pending bit i at the next clock edge. The bit stays set, whatever the mask holds, until a pending-register read clears it.
- R3: A read with `reg_sel`=1 returns the pending bits as they stood before that edge. At the same edge it clears all of them.
- R4: An event pulse in the same cycle as a clearing read is kept as pending after that edge. It is not included in that read's data.
- R5: Pending bits 9, 12, 14 and 15 always read as zero, and pulses on those event inputs never raise `irq` or a class output.
- R6: `irq` is high exactly when mask bit 15 is set and (pending AND mask AND 0x2DFF) is nonzero. It reflects a new event or mask one cycle after the pulse or write.
- R7: While mask bit 15 is clear, `irq`, `cls_link` and `cls_fifo` are low, whatever is pending or enabled in bits 0-13.
- R8: `cls_link` is high when mask bit 15 is set and (pending AND mask) has any of bits 10, 11 or 13 set.
- R9: `cls_fifo` is high when mask bit 15 is set and (pending AND mask) has bit 5 or bit 6 set.
- R10: A write with `reg_sel`=0 loads the mask with `wr_data` AND 0xADFF. Reserved bits 9, 12 and 14 read as zero. Writing zero turns off all interrupt generation.
- R11: `rd_valid` is high, with `rd_data`, for exactly the one cycle after each read strobe.
- R12: A read with `reg_sel`=0 returns the mask and leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 16 | Single-cycle event pulses, one bit per cause |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 1 | 0 selects the mask register, 1 selects the pending register |
| wr_data | input | 16 | Write data for the mask register |
| rd_data | output | 16 | Read response data |
| rd_valid | output | 1 | Read response strobe |
| irq | output | 1 | Level-sensitive interrupt, active high |
| cls_link | output | 1 | Link/configuration-change class summary |
| cls_fifo | output | 1 | FIFO-error class summary |

## Verification
The main function is tried with several patterns:

- Single events of each class, with the master bit both clear and set. This separates gating by bit 15 from gating by the per-bit mask.
- Events arriving while masked and then unmasked later. This shows that pending bits stick independently of the mask.
- A pulse landing in the same cycle as a clearing read. This separates a correct clear from one that drops coincident events.
- Pulses on reserved positions, and a mask read between events. These show that reserved lanes stay inert and that only a pending-register read clears anything.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int REG_W      = 16;
    localparam int MASTER_BIT = 15;
    localparam int N_CLASS    = 2;

    // Positions that carry a real event
    localparam logic [REG_W-1:0] EVT_VALID   = 16'h2DFF;
    // Writable mask bits: the event lanes plus the master switch
    localparam logic [REG_W-1:0] EN_WRITABLE = EVT_VALID | (16'h1 << MASTER_BIT);
    // Class membership, class 0 is link/config change, class 1 is FIFO error
    localparam logic [REG_W-1:0] CLS_LINK_MASK = 16'h2C00;
    localparam logic [REG_W-1:0] CLS_FIFO_MASK = 16'h0060;

    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

    typedef enum logic [1:0] {
        PORT_IDLE      = 2'd0,
        PORT_RESP_EN   = 2'd1,
        PORT_RESP_STAT = 2'd2
    } port_state_t;

endpackage

// File: rtl/phy_irq_event_bank.sv
module phy_irq_event_bank
    import phy_irq_pkg::*;
#(
    parameter int             W          = REG_W,
    parameter logic [W-1:0]   VALID_MASK = EVT_VALID
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] status
);

    // One sticky flop per live lane, reserved lanes tied low
    for (genvar i = 0; i < W; i++) begin : g_lane
        if (VALID_MASK[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= (bit_q & ~clr) | evt[i];
                end
            end
            assign status[i] = bit_q;
        end else begin : g_rsvd
            assign status[i] = 1'b0;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> ((status & $past(status)) == $past(status))); // R2

    AST_EVT_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(evt) & VALID_MASK)) |->
            ((status & $past(evt) & VALID_MASK) == ($past(evt) & VALID_MASK))); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> ((status & ~$past(evt)) == '0)); // R3

endmodule

// File: rtl/phy_irq_regport.sv
module phy_irq_regport
    import phy_irq_pkg::*;
#(
    parameter int           W       = REG_W,
    parameter logic [W-1:0] EN_MASK = EN_WRITABLE
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic         sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         clr_status
);

    port_state_t  state_q, state_d;
    logic [W-1:0] data_q;
    logic [W-1:0] enable_q;

    // Next-state: go_resp_stat, go_resp_en, go_idle
    always_comb begin
        state_d = PORT_IDLE;
        if (rd_en) begin
            state_d = (sel == SEL_STATUS) ? PORT_RESP_STAT : PORT_RESP_EN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= (sel == SEL_STATUS) ? status : enable_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_en && (sel == SEL_ENABLE)) begin
            enable_q <= wr_data & EN_MASK;
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            PORT_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            PORT_RESP_EN, PORT_RESP_STAT: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    assign enable     = enable_q;
    assign clr_status = rd_en && (sel == SEL_STATUS);

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R11

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (sel == SEL_ENABLE)) |-> (enable == ($past(wr_data) & EN_MASK))); // R10

    AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (sel == SEL_ENABLE)) |-> ((rd_data & ~EN_MASK) == '0)); // R10

endmodule

// File: rtl/phy_irq_classify.sv
module phy_irq_classify
    import phy_irq_pkg::*;
#(
    parameter int                          W          = REG_W,
    parameter int                          NC         = N_CLASS,
    parameter int                          MBIT       = MASTER_BIT,
    parameter logic [W-1:0]                VALID_MASK = EVT_VALID,
    parameter logic [NC-1:0][W-1:0]        CLS_MASKS  = {CLS_FIFO_MASK, CLS_LINK_MASK}
)
(
    input  logic [W-1:0]  status,
    input  logic [W-1:0]  enable,
    output logic          irq,
    output logic [NC-1:0] cls
);

    logic [W-1:0] live;

    assign live = status & enable & VALID_MASK;
    assign irq  = enable[MBIT] && (|live);

    for (genvar c = 0; c < NC; c++) begin : g_cls
        assign cls[c] = enable[MBIT] && (|(live & CLS_MASKS[c]));
    end

endmodule

// File: rtl/phy_irq_aggregator.sv
module phy_irq_aggregator
    import phy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              irq,
    output logic              cls_link,
    output logic              cls_fifo
);

    logic [REG_W-1:0]   status;
    logic [REG_W-1:0]   enable;
    logic               clr_status;
    logic [N_CLASS-1:0] cls;

    phy_irq_event_bank #(.W(REG_W), .VALID_MASK(EVT_VALID)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .clr    (clr_status),
        .status (status)
    );

    phy_irq_regport #(.W(REG_W), .EN_MASK(EN_WRITABLE)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .sel        (reg_sel),
        .wr_data    (wr_data),
        .status     (status),
        .enable     (enable),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .clr_status (clr_status)
    );

    phy_irq_classify #(.W(REG_W), .NC(N_CLASS), .MBIT(MASTER_BIT)) u_cls (
        .status (status),
        .enable (enable),
        .irq    (irq),
        .cls    (cls)
    );

    assign cls_link = cls[0];
    assign cls_fifo = cls[1];

    AST_CLASS_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_link || cls_fifo) |-> irq); // R8

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable[MASTER_BIT] |-> !(irq || cls_link || cls_fifo)); // R7

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_pulse & ~EVT_VALID) != '0) && ($past(status) == '0) &&
        ($past(evt_pulse & EVT_VALID) == '0) |-> !irq); // R5

endmodule

// File: tb/phy_irq_aggregator_test.sv
`timescale 1ns/1ps
module phy_irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_pulse = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        irq;
    logic        cls_link;
    logic        cls_fifo;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    logic [15:0] m_status = '0;
    logic [15:0] m_enable = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    phy_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rd_en(rd_en),
        .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .irq(irq), .cls_link(cls_link), .cls_fifo(cls_fifo)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 16'h1, 16'h0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: one bus cycle, expectations pushed before the edge
    task automatic cycle(input logic rd, input logic wr, input logic sel,
                         input logic [15:0] wd, input logic [15:0] ev, input string req);
        rd_en = rd; wr_en = wr; reg_sel = sel; wr_data = wd; evt_pulse = ev;
        if (rd) begin
            exp_q.push_back(sel ? m_status : m_enable);
            tag_q.push_back(req);
        end
        if (rd && sel) m_status = ev & 16'h2DFF;
        else           m_status = m_status | (ev & 16'h2DFF);
        if (wr && !sel) m_enable = wd & 16'hADFF;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; evt_pulse = '0; wr_data = '0;
    endtask

    task automatic check_outs(input string req);
        logic [15:0] live;
        live = m_status & m_enable & 16'h2DFF;
        check({req, " irq"},  {15'd0, irq},      {15'd0, m_enable[15] && (|live)});
        check({req, " link"}, {15'd0, cls_link}, {15'd0, m_enable[15] && (|(live & 16'h2C00))});
        check({req, " fifo"}, {15'd0, cls_fifo}, {15'd0, m_enable[15] && (|(live & 16'h0060))});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_valid", {15'd0, rd_valid}, 16'h0);
        check_outs("R1");
        cycle(1, 0, 1, 16'h0, 16'h0, "R1 status after reset");
        cycle(1, 0, 0, 16'h0, 16'h0, "R1 enable after reset");
        // R11 single-cycle response
        check("R11 valid high", {15'd0, rd_valid}, 16'h1);
        @(negedge clk);
        check("R11 valid low", {15'd0, rd_valid}, 16'h0);

        // R7 master off
        cycle(0, 0, 0, 16'h0, 16'h0001, "");
        check_outs("R7 no enable");
        cycle(0, 1, 0, 16'h0001, 16'h0, "");
        check_outs("R7 bit0 enabled master off");
        // R6 master on
        cycle(0, 1, 0, 16'h8001, 16'h0, "");
        check_outs("R6 irq on");
        check("R6 irq value", {15'd0, irq}, 16'h1);
        // R3 read clears
        cycle(1, 0, 1, 16'h0, 16'h0, "R3 read data");
        check_outs("R3 after clear");
        cycle(1, 0, 1, 16'h0, 16'h0, "R3 second read empty");

        // R2 sticky while masked
        cycle(0, 0, 0, 16'h0, 16'h2000, "");
        check_outs("R6 masked link");
        repeat (3) @(negedge clk);
        cycle(0, 1, 0, 16'hA001, 16'h0, "");
        check_outs("R8 link unmasked");
        check("R2 sticky link", {15'd0, cls_link}, 16'h1);
        cycle(1, 0, 1, 16'h0, 16'h0, "R2 sticky read");
        // R8 autoneg bits
        cycle(0, 1, 0, 16'h8C00, 16'h0400, "");
        check_outs("R8 aneg done");
        cycle(1, 0, 1, 16'h0, 16'h0800, "R8 read keeps aneg err");
        check_outs("R8 aneg err");
        cycle(1, 0, 1, 16'h0, 16'h0, "R8 aneg err read");
        // R9 fifo class
        cycle(0, 1, 0, 16'h8060, 16'h0020, "");
        check_outs("R9 rx fifo");
        check("R9 fifo value", {15'd0, cls_fifo}, 16'h1);
        cycle(1, 0, 1, 16'h0, 16'h0, "R9 read rx");
        cycle(0, 0, 0, 16'h0, 16'h0040, "");
        check_outs("R9 tx fifo");
        cycle(1, 0, 1, 16'h0, 16'h0, "R9 read tx");

        // R5 reserved lanes, R10 mask readback
        cycle(0, 1, 0, 16'hFFFF, 16'hD200, "");
        check_outs("R5 reserved pulses");
        check("R5 irq low", {15'd0, irq}, 16'h0);
        cycle(1, 0, 0, 16'h0, 16'h0, "R10 enable readback");
        cycle(1, 0, 1, 16'h0, 16'h0, "R5 status reads zero");

        // R4 coincident event and clear
        cycle(0, 0, 0, 16'h0, 16'h0008, "");
        cycle(1, 0, 1, 16'h0, 16'h0100, "R4 read excludes new");
        check_outs("R4 kept");
        check("R4 irq from kept", {15'd0, irq}, 16'h1);
        cycle(1, 0, 1, 16'h0, 16'h0, "R4 kept bit read");

        // R12 enable read does not clear
        cycle(0, 0, 0, 16'h0, 16'h0010, "");
        cycle(1, 0, 0, 16'h0, 16'h0, "R12 enable read");
        check_outs("R12 still pending");
        // R10 write zero
        cycle(0, 1, 0, 16'h0000, 16'h0, "");
        check_outs("R10 zero mask");
        check("R10 irq off", {15'd0, irq}, 16'h0);
        cycle(1, 0, 1, 16'h0, 16'h0, "R12 status kept");

        @(negedge clk);
        #1;
        check("R11 queue drained", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule